// File: doc/BRIEF.md
# Valid-Frame Report Notifier and Serializer

This block tells a host controller that a valid radio frame has been accepted, then hands the host an 80-bit report over a two-wire synchronous link. The host owns the clock line. The block drives the shared data line through an output enable. When a report is ready, the block first checks for a clash with a host command request. If there is none, it raises the data line and waits for the host to raise the clock.

A clock rise that comes too soon after the notification is taken as a command request, and the block yields. A later rise is acknowledged by pulling the data line low. The host then clocks the report out one bit per rising edge. The transfer ends after the last bit or when the clock stays low too long.

All intervals are counted in ticks of a free-running prescaler. The clock line is passed through a two-flop synchronizer and an edge detector before use.

Top module: `frame_report_tx`

## Requirements
- R1: After reset the data line is released (`link_oe`=0), and `xfer_done` and `cmd_yield` are low.
- R2: A ready strobe that arrives while the synchronized clock line is high drops the report. It gives a one-cycle `cmd_yield` pulse and leaves the data line released.
- R3: A ready strobe that arrives with the clock line low starts a notification. The data line is driven high (`link_oe`=1, `link_dout`=1).
- R4: A clock rise during a notification, less than GUARD_TICKS ticks after it began, gives a `cmd_yield` pulse and releases the data line.
- R5: A clock rise during a notification, GUARD_TICKS or more ticks after it began, is acknowledged. The data line is driven low on the cycle after the rise is detected.
- R6: A notification that sees no clock rise for WAIT_TICKS ticks releases the data line. It gives neither a `xfer_done` nor a `cmd_yield` pulse.
- R7: After the acknowledge, each host clock rising edge presents the next report bit on `link_dout`. Bit k of the report goes out on the (k+1)-th rise. The report bits are:
  - 0: a 0 start bit
  - 1: repeat flag
  - 2: low-battery flag
  - 6:3: function code, LSB first
  - 7: a 1 stop bit
  - 11:8: learned count, LSB first
  - 15:12: slot index, LSB first
  - 79:16: received word, LSB first
- R8: The first falling edge of the host clock after the 80th bit gives a one-cycle `xfer_done` pulse and releases the line. No more than 80 bits are ever presented.
- R9: During the transfer, if the clock line stays low for IDLE_TICKS ticks, the transfer ends at whatever bit was reached. This gives a `xfer_done` pulse and releases the line.
- R10: A ready strobe that arrives while a notification or transfer is in progress is ignored. The bits still to be sent come from the report captured at the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rpt_valid | input | 1 | One-cycle strobe: report fields are valid |
| rpt_repeat | input | 1 | Repeated-frame flag |
| rpt_vlow | input | 1 | Low transmitter battery flag |
| rpt_func | input | 4 | Function (button) code |
| rpt_count | input | 4 | Number of learned transmitters |
| rpt_slot | input | 4 | Slot index of the matching transmitter |
| rpt_rx | input | 64 | Received frame with decrypted part |
| link_clk | input | 1 | Host-driven clock line (asynchronous) |
| link_dout | output | 1 | Data line value driven by the block |
| link_oe | output | 1 | Data line output enable |
| xfer_done | output | 1 | One-cycle pulse: report transfer finished |
| cmd_yield | output | 1 | One-cycle pulse: notification dropped in favour of a host command |

## Verification
A change on the host clock reaches the outputs three block cycles later: two synchronizer flops, then the state register. The bench therefore drives the clock line at a falling edge of the block clock and samples four cycles later, again at a falling edge. The line state at the start of a notification appears three cycles after the ready strobe is lowered.

The pulses on `xfer_done` and `cmd_yield` last one cycle. They are counted by a falling-edge monitor, and each scenario compares the counts before and after. The tick-based windows are exercised with margins of at least one full tick on both sides, because the prescaler phase is free-running.

// File: rtl/frame_report_tx.sv
module frame_report_tx #(
  parameter int TICK_DIV    = 200,
  parameter int GUARD_TICKS = 50,
  parameter int WAIT_TICKS  = 500000,
  parameter int IDLE_TICKS  = 1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rpt_valid,
  input  logic        rpt_repeat,
  input  logic        rpt_vlow,
  input  logic [3:0]  rpt_func,
  input  logic [3:0]  rpt_count,
  input  logic [3:0]  rpt_slot,
  input  logic [63:0] rpt_rx,
  input  logic        link_clk,
  output logic        link_dout,
  output logic        link_oe,
  output logic        xfer_done,
  output logic        cmd_yield
);
  localparam int RW = 80;
  localparam int IW = $clog2(RW + 1);
  localparam int CW = $clog2(WAIT_TICKS + GUARD_TICKS + IDLE_TICKS + 1);
  localparam int DW = $clog2(TICK_DIV + 1);
  localparam logic [CW-1:0] GUARD_C = CW'(GUARD_TICKS);
  localparam logic [CW-1:0] WAIT_C  = CW'(WAIT_TICKS);
  localparam logic [CW-1:0] IDLE_C  = CW'(IDLE_TICKS);
  localparam logic [DW-1:0] DIV_END = DW'(TICK_DIV - 1);
  localparam logic [IW-1:0] LAST    = IW'(RW);

  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_NOTE = 2'd1, ST_SEND = 2'd2} st_t;

  st_t           st;
  logic [2:0]    csync;
  logic [DW-1:0] pre;
  logic [CW-1:0] tcnt;
  logic [IW-1:0] idx;
  logic [RW-1:0] rpt;
  logic          tick, c_lvl, c_rise, c_fall;
  logic [RW-1:0] frame;

  assign c_lvl  = csync[1];
  assign c_rise = csync[1] & ~csync[2];
  assign c_fall = ~csync[1] & csync[2];
  assign tick   = (pre == DIV_END);
  assign frame  = {rpt_rx, rpt_slot, rpt_count, 1'b1, rpt_func, rpt_vlow, rpt_repeat, 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csync <= '0;
      pre   <= '0;
    end else begin
      csync <= {csync[1:0], link_clk};
      pre   <= tick ? '0 : pre + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      link_oe   <= 1'b0;
      link_dout <= 1'b0;
      xfer_done <= 1'b0;
      cmd_yield <= 1'b0;
      tcnt      <= '0;
      idx       <= '0;
      rpt       <= '0;
    end else begin
      xfer_done <= 1'b0;
      cmd_yield <= 1'b0;
      if (tick && tcnt != '1) tcnt <= tcnt + 1'b1;
      case (st)
        ST_IDLE: begin
          link_oe   <= 1'b0;
          link_dout <= 1'b0;
          if (rpt_valid) begin
            if (c_lvl) begin
              cmd_yield <= 1'b1;
            end else begin
              rpt       <= frame;
              st        <= ST_NOTE;
              link_oe   <= 1'b1;
              link_dout <= 1'b1;
              tcnt      <= '0;
            end
          end
        end
        ST_NOTE: begin
          if (c_rise) begin
            if (tcnt < GUARD_C) begin
              cmd_yield <= 1'b1;
              st        <= ST_IDLE;
              link_oe   <= 1'b0;
              link_dout <= 1'b0;
            end else begin
              st        <= ST_SEND;
              link_dout <= 1'b0;
              idx       <= '0;
              tcnt      <= '0;
            end
          end else if (tcnt >= WAIT_C) begin
            st        <= ST_IDLE;
            link_oe   <= 1'b0;
            link_dout <= 1'b0;
          end
        end
        ST_SEND: begin
          if (c_lvl) tcnt <= '0;
          if (c_rise && idx != LAST) begin
            link_dout <= rpt[0];
            rpt       <= rpt >> 1;
            idx       <= idx + 1'b1;
          end
          if ((c_fall && idx == LAST) || (!c_lvl && tcnt >= IDLE_C)) begin
            xfer_done <= 1'b1;
            st        <= ST_IDLE;
            link_oe   <= 1'b0;
            link_dout <= 1'b0;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/frame_report_tx_chk.sv
module frame_report_tx_chk #(
  parameter int CW = 8,
  parameter int IW = 7,
  parameter int GUARD_TICKS = 50,
  parameter int WAIT_TICKS  = 500
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    st,
  input logic          c_rise,
  input logic [CW-1:0] tcnt,
  input logic [IW-1:0] idx,
  input logic          link_oe,
  input logic          link_dout,
  input logic          xfer_done,
  input logic          cmd_yield
);
  localparam logic [CW-1:0] G = CW'(GUARD_TICKS);
  localparam logic [CW-1:0] W = CW'(WAIT_TICKS);

  // R1
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd0) |-> !link_oe);

  // R3
  note_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd1) |-> (link_oe && link_dout));

  // R4
  early_yield_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd1 && c_rise && tcnt < G) |=> (cmd_yield && !link_oe));

  // R5
  ack_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd1 && c_rise && tcnt >= G && tcnt < W) |=> (link_oe && !link_dout));

  // R8
  bit_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= IW'(80));

  // R8
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(xfer_done && cmd_yield));
endmodule

bind frame_report_tx frame_report_tx_chk #(
  .CW(CW), .IW(IW), .GUARD_TICKS(GUARD_TICKS), .WAIT_TICKS(WAIT_TICKS)
) chk_i (
  .clk(clk), .rst_n(rst_n), .st(st), .c_rise(c_rise), .tcnt(tcnt), .idx(idx),
  .link_oe(link_oe), .link_dout(link_dout), .xfer_done(xfer_done), .cmd_yield(cmd_yield)
);

// File: tb/frame_report_tx_tb_top.sv
`timescale 1ns/1ps
module frame_report_tx_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rpt_valid = 1'b0;
  logic        rpt_repeat = 1'b0;
  logic        rpt_vlow = 1'b0;
  logic [3:0]  rpt_func = '0;
  logic [3:0]  rpt_count = '0;
  logic [3:0]  rpt_slot = '0;
  logic [63:0] rpt_rx = '0;
  logic        link_clk = 1'b0;
  logic        link_dout, link_oe, xfer_done, cmd_yield;

  int n_chk = 0, n_bad = 0, n_done = 0, n_yield = 0;

  always #2.5 clk = ~clk;

  frame_report_tx #(.TICK_DIV(4), .GUARD_TICKS(5), .WAIT_TICKS(60), .IDLE_TICKS(10)) dut_i (
    .clk(clk), .rst_n(rst_n), .rpt_valid(rpt_valid), .rpt_repeat(rpt_repeat),
    .rpt_vlow(rpt_vlow), .rpt_func(rpt_func), .rpt_count(rpt_count), .rpt_slot(rpt_slot),
    .rpt_rx(rpt_rx), .link_clk(link_clk), .link_dout(link_dout), .link_oe(link_oe),
    .xfer_done(xfer_done), .cmd_yield(cmd_yield));

  always @(negedge clk) begin
    if (xfer_done) n_done++;
    if (cmd_yield) n_yield++;
  end

  task automatic chk(input string req, input logic [79:0] act, input logic [79:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [79:0] exp_frame();
    logic [79:0] f;
    f[0] = 1'b0; f[1] = rpt_repeat; f[2] = rpt_vlow; f[6:3] = rpt_func;
    f[7] = 1'b1; f[11:8] = rpt_count; f[15:12] = rpt_slot; f[79:16] = rpt_rx;
    return f;
  endfunction

  task automatic strobe();
    rpt_valid = 1'b1; cyc(1); rpt_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 oe", 80'(link_oe), 80'd0);
    chk("R1 done", 80'(xfer_done), 80'd0);
    chk("R1 yield", 80'(cmd_yield), 80'd0);
  endtask

  task automatic t_collide();
    int y0 = n_yield;
    link_clk = 1'b1; cyc(4);
    strobe(); cyc(3);
    chk("R2 yield", 80'(n_yield - y0), 80'd1);
    chk("R2 oe", 80'(link_oe), 80'd0);
    link_clk = 1'b0; cyc(4);
  endtask

  task automatic t_early();
    int y0 = n_yield;
    strobe(); cyc(3);
    chk("R3 oe", 80'(link_oe), 80'd1);
    chk("R3 dout", 80'(link_dout), 80'd1);
    link_clk = 1'b1; cyc(4);
    chk("R4 yield", 80'(n_yield - y0), 80'd1);
    chk("R4 oe", 80'(link_oe), 80'd0);
    link_clk = 1'b0; cyc(4);
  endtask

  task automatic t_wait_out();
    int y0 = n_yield, d0 = n_done;
    strobe(); cyc(200);
    chk("R6 still driving", 80'(link_oe), 80'd1);
    cyc(70);
    chk("R6 released", 80'(link_oe), 80'd0);
    chk("R6 no pulses", 80'((n_yield - y0) + (n_done - d0)), 80'd0);
  endtask

  task automatic t_full(input logic rep, input logic vl, input logic [3:0] fn,
                        input logic [3:0] cn, input logic [3:0] sl, input logic [63:0] rx);
    logic [79:0] ef;
    int d0 = n_done, bad = 0;
    rpt_repeat = rep; rpt_vlow = vl; rpt_func = fn; rpt_count = cn; rpt_slot = sl; rpt_rx = rx;
    ef = exp_frame();
    strobe(); cyc(40);
    link_clk = 1'b1; cyc(4);
    chk("R5 ack oe", 80'(link_oe), 80'd1);
    chk("R5 ack low", 80'(link_dout), 80'd0);
    link_clk = 1'b0; cyc(4);
    for (int i = 0; i < 80; i++) begin
      if (i == 40) begin
        rpt_rx = ~rx; rpt_slot = ~sl; strobe();
      end
      link_clk = 1'b1; cyc(4);
      if (link_dout !== ef[i]) bad++;
      link_clk = 1'b0; cyc(4);
    end
    chk("R7 R10 bit mismatches", 80'(bad), 80'd0);
    chk("R8 done", 80'(n_done - d0), 80'd1);
    chk("R8 released", 80'(link_oe), 80'd0);
  endtask

  task automatic t_idle_cut();
    logic [79:0] ef;
    int d0 = n_done, bad = 0;
    rpt_rx = 64'h0123_4567_89AB_CDEF; rpt_func = 4'h9;
    ef = exp_frame();
    strobe(); cyc(40);
    link_clk = 1'b1; cyc(4);
    link_clk = 1'b0; cyc(4);
    for (int i = 0; i < 12; i++) begin
      link_clk = 1'b1; cyc(4);
      if (link_dout !== ef[i]) bad++;
      link_clk = 1'b0; cyc(4);
    end
    chk("R9 partial bits", 80'(bad), 80'd0);
    cyc(26);
    chk("R9 before cutoff", 80'(link_oe), 80'd1);
    cyc(30);
    chk("R9 done", 80'(n_done - d0), 80'd1);
    chk("R9 released", 80'(link_oe), 80'd0);
  endtask

  initial begin
    cyc(3);
    t_reset();
    rst_n = 1'b1; cyc(3);
    t_reset();
    t_collide();
    t_early();
    t_wait_out();
    t_full(1'b1, 1'b0, 4'hA, 4'h3, 4'h5, 64'hDEAD_BEEF_0F1E_2D3C);
    t_full(1'b0, 1'b1, 4'h1, 4'h7, 4'h6, 64'h8000_0000_0000_0001);
    t_idle_cut();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule